// File: doc/BRIEF.md
# I2C Interrupt Vector and Mask Unit

This unit gathers the single-cycle event pulses raised by an I2C controller core and latches each one into a sticky status flag. An enable register selects which flags may raise the shared interrupt line. A vector register reports, as a 3-bit code, the most urgent flag that is both pending and enabled. A handler can therefore take one read to learn what happened, instead of scanning a bitmap.

Reading the vector acknowledges the flag it names. The receive-ready and transmit-ready flags are the exception. They stay pending until the data path reports that the receive data was taken or that new transmit data was loaded. Software can also clear any flag by writing a one to its status bit.

The register port is a simple single-cycle strobe interface with no back-pressure. Read data is registered: it appears in the cycle after the read strobe and holds until the next read. The event sources, the data registers and the bus engine sit outside this block.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset every status flag and every enable bit is 0, `irq` is 0 and `reg_rdata` is 0.
- R2: A pulse on `ev_pulse[i]` sets status flag i whether or not it is enabled. The flag positions are arbitration-lost 0, no-acknowledge 1, access-ready 2, receive-ready 3, transmit-ready 4, stop-detected 5 and addressed-as-slave 6. Status is read at offset 0x08.
- R3: The enable register at offset 0x04 stores write data bits 6..0 and reads them back in the same positions. Its other bits read as 0.
- R4: `irq` is 1 exactly when some flag in bits 6..0 is set while its enable bit is also set.
- R5: A read at offset 0x28 returns the code of the lowest-numbered flag that is pending and enabled, in bits 2..0. That code is the bit position plus 1: arbitration-lost gives 1 and addressed-as-slave gives 7. The read returns 0 when nothing enabled is pending.
- R6: A vector read clears the flag it reports for codes 1, 2, 3, 6 and 7. For codes 4 (receive-ready) and 5 (transmit-ready) it leaves the flag set.
- R7: A pulse on `rx_data_taken` clears receive-ready (bit 3). A pulse on `tx_data_loaded` clears transmit-ready (bit 4).
- R8: A write to the status offset clears each flag whose write-data bit is 1 and leaves the other flags unchanged.
- R9: A status read reports the `rx_shift_full` input at bit 11 and the `bus_busy` input at bit 12, as sampled in the read cycle.
- R10: If an event pulse arrives in the same cycle as any clear of that flag, the flag ends up set.
- R11: A read of any offset other than 0x04, 0x08 or 0x28 returns 0. A write to the vector offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_pulse | input | 7 | One-cycle event pulses, bit positions as in R2 |
| bus_busy | input | 1 | Bus-busy level, reported in status bit 12 |
| rx_shift_full | input | 1 | Receive-shift-full level, reported in status bit 11 |
| rx_data_taken | input | 1 | Pulse: receive data register was read |
| tx_data_loaded | input | 1 | Pulse: transmit data register was written |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data, held between reads |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take each event input to be a one-cycle pulse. They also take a read and a write to the same cycle only when that overlap is itself under test. None of them depends on the `bus_busy` or `rx_shift_full` levels. The directed stimulus raises every event by itself and then in groups. It walks the vector through every code with all sources enabled and then with sparse enable patterns. It lines up a set and a clear in the same cycle on purpose. A seeded random phase then mixes pulses, reads and writes, but never asserts `reg_rd` and `reg_wr` together. The reference model judges every cycle of that mix.

// File: rtl/i2civ_pkg.sv
package i2civ_pkg;
  localparam int N_EV   = 7;
  localparam int CODE_W = $clog2(N_EV + 1);

  // flag positions, also the vector priority order (lower wins)
  localparam int B_AL   = 0;
  localparam int B_NACK = 1;
  localparam int B_ARDY = 2;
  localparam int B_RRDY = 3;
  localparam int B_XRDY = 4;
  localparam int B_SCD  = 5;
  localparam int B_AAS  = 6;

  // level inputs mirrored into the status word
  localparam int B_RSF  = 11;
  localparam int B_BUSY = 12;

  // flags that a vector read must not acknowledge
  localparam logic [N_EV-1:0] DATA_HELD = (N_EV'(1) << B_RRDY) | (N_EV'(1) << B_XRDY);

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT,
    SEL_VEC
  } regsel_e;
endpackage

// File: rtl/ivu_flags.sv
module ivu_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // one sticky cell per source; a new event outranks any clear
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio #(
  parameter int N      = 7,
  parameter int CODE_W = 3
) (
  input  logic [N-1:0]      req_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N-1:0]      grant_o
);
  // scan from the top so the lowest set index is the last to write
  always_comb begin
    code_o  = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o  = CODE_W'(i + 1);
        grant_o = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/ivu_regs.sv
module ivu_regs
  import i2civ_pkg::*;
#(
  parameter int          N        = N_EV,
  parameter int          CW       = CODE_W,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 16,
  parameter logic [7:0]  OFF_MASK = 8'h04,
  parameter logic [7:0]  OFF_STAT = 8'h08,
  parameter logic [7:0]  OFF_VEC  = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [N-1:0]      stat_i,
  input  logic [CW-1:0]     vec_code_i,
  input  logic [N-1:0]      vec_grant_i,
  input  logic              bus_busy,
  input  logic              rx_shift_full,
  input  logic              rx_data_taken,
  input  logic              tx_data_loaded,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] reg_rdata
);
  regsel_e            sel;
  logic [DATA_W-1:0]  rd_next;
  logic               vec_ack;
  logic [N-1:0]       w1c;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:N];

  always_comb begin
    if      (reg_addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
    else if (reg_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (reg_addr == ADDR_W'(OFF_VEC))  sel = SEL_VEC;
    else                                    sel = SEL_NONE;
  end

  assign vec_ack = reg_rd && (sel == SEL_VEC);
  assign w1c     = (reg_wr && (sel == SEL_STAT)) ? reg_wdata[N-1:0] : '0;

  always_comb begin
    clr_o = w1c;
    if (vec_ack) clr_o = clr_o | (vec_grant_i & ~DATA_HELD);
    if (rx_data_taken)  clr_o[B_RRDY] = 1'b1;
    if (tx_data_loaded) clr_o[B_XRDY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                              mask_o <= '0;
    else if (reg_wr && (sel == SEL_MASK)) mask_o <= reg_wdata[N-1:0];
  end

  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_MASK: rd_next[N-1:0] = mask_o;
      SEL_STAT: begin
        rd_next[N-1:0] = stat_i;
        rd_next[B_RSF] = rx_shift_full;
        rd_next[B_BUSY] = bus_busy;
      end
      SEL_VEC:  rd_next[CW-1:0] = vec_code_i;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2civ_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 16,
  parameter logic [7:0] OFF_MASK = 8'h04,
  parameter logic [7:0] OFF_STAT = 8'h08,
  parameter logic [7:0] OFF_VEC  = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EV-1:0]   ev_pulse,
  input  logic              bus_busy,
  input  logic              rx_shift_full,
  input  logic              rx_data_taken,
  input  logic              tx_data_loaded,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [N_EV-1:0]   stat_q;
  logic [N_EV-1:0]   mask_q;
  logic [N_EV-1:0]   clr;
  logic [N_EV-1:0]   grant;
  logic [CODE_W-1:0] code;

  ivu_flags #(.N(N_EV)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (ev_pulse),
    .clr_i (clr),
    .q_o   (stat_q)
  );

  ivu_prio #(.N(N_EV), .CODE_W(CODE_W)) u_prio (
    .req_i   (stat_q & mask_q),
    .code_o  (code),
    .grant_o (grant)
  );

  ivu_regs #(
    .N(N_EV), .CW(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFF_MASK(OFF_MASK), .OFF_STAT(OFF_STAT), .OFF_VEC(OFF_VEC)
  ) u_regs (
    .clk            (clk),
    .rst            (rst),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .reg_rd         (reg_rd),
    .stat_i         (stat_q),
    .vec_code_i     (code),
    .vec_grant_i    (grant),
    .bus_busy       (bus_busy),
    .rx_shift_full  (rx_shift_full),
    .rx_data_taken  (rx_data_taken),
    .tx_data_loaded (tx_data_loaded),
    .mask_o         (mask_q),
    .clr_o          (clr),
    .reg_rdata      (reg_rdata)
  );

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/ivu_chk.sv
module ivu_chk
  import i2civ_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 16,
  parameter logic [7:0] OFF_STAT = 8'h08,
  parameter logic [7:0] OFF_VEC  = 8'h28
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EV-1:0]   ev_pulse,
  input logic              rx_data_taken,
  input logic              tx_data_loaded,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [N_EV-1:0]   stat_q,
  input logic [N_EV-1:0]   mask_q
);
  logic vec_rd, stat_wr;
  assign vec_rd  = reg_rd && (reg_addr == ADDR_W'(OFF_VEC));
  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && reg_rdata == '0));

  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_pulse != '0) |=> ((stat_q & $past(ev_pulse)) == $past(ev_pulse)));

  // R5
  empty_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && (stat_q & mask_q) == '0) |=> (reg_rdata == '0));

  // R6
  vec_ack_al_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && stat_q[B_AL] && mask_q[B_AL] && !ev_pulse[B_AL]) |=> !stat_q[B_AL]);

  // R6
  vec_keeps_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && stat_q[B_RRDY] && !rx_data_taken && !(stat_wr && reg_wdata[B_RRDY]))
      |=> stat_q[B_RRDY]);

  // R7
  rx_take_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_data_taken && !ev_pulse[B_RRDY]) |=> !stat_q[B_RRDY]);

  // R7
  tx_load_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_data_loaded && !ev_pulse[B_XRDY]) |=> !stat_q[B_XRDY]);

  // R8
  w1c_scd_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && reg_wdata[B_SCD] && !ev_pulse[B_SCD]) |=> !stat_q[B_SCD]);
endmodule

bind i2c_irq_vector ivu_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_STAT(OFF_STAT), .OFF_VEC(OFF_VEC)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ev_pulse       (ev_pulse),
  .rx_data_taken  (rx_data_taken),
  .tx_data_loaded (tx_data_loaded),
  .reg_addr       (reg_addr),
  .reg_wr         (reg_wr),
  .reg_wdata      (reg_wdata),
  .reg_rd         (reg_rd),
  .reg_rdata      (reg_rdata),
  .irq            (irq),
  .stat_q         (stat_q),
  .mask_q         (mask_q)
);

// File: tb/sim_i2c_irq_vector.sv
module sim_i2c_irq_vector;
  localparam logic [7:0] A_MASK = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_VEC  = 8'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  ev_pulse = '0;
  logic        bus_busy = 1'b0;
  logic        rx_shift_full = 1'b0;
  logic        rx_data_taken = 1'b0;
  logic        tx_data_loaded = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";

  // reference state
  logic [6:0]  m_stat = '0;
  logic [6:0]  m_mask = '0;
  logic [15:0] m_rd = '0;

  always #4 clk = ~clk;

  i2c_irq_vector u0 (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .bus_busy(bus_busy),
    .rx_shift_full(rx_shift_full), .rx_data_taken(rx_data_taken),
    .tx_data_loaded(tx_data_loaded), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check16(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int vcode(input logic [6:0] p);
    int c = 0;
    for (int i = 6; i >= 0; i--) if (p[i]) c = i + 1;
    return c;
  endfunction

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic [6:0] ev, input bit rd, input bit wr,
                      input logic [7:0] a, input logic [15:0] wd,
                      input bit rt, input bit tl);
    logic [6:0] clr;
    int c;
    ev_pulse = ev; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    rx_data_taken = rt; tx_data_loaded = tl;
    @(posedge clk);
    c = vcode(m_stat & m_mask);
    if (rd) begin
      if (a == A_MASK)      m_rd = {9'd0, m_mask};
      else if (a == A_STAT) m_rd = {3'd0, bus_busy, rx_shift_full, 4'd0, m_stat};
      else if (a == A_VEC)  m_rd = 16'(c);
      else                  m_rd = '0;
    end
    clr = '0;
    if (wr && a == A_STAT) clr = clr | wd[6:0];
    if (rd && a == A_VEC && c != 0 && c != 4 && c != 5) clr[c-1] = 1'b1;
    if (rt) clr[3] = 1'b1;
    if (tl) clr[4] = 1'b1;
    if (wr && a == A_MASK) m_mask = wd[6:0];
    m_stat = (m_stat & ~clr) | ev;
    @(negedge clk);
    ev_pulse = '0; reg_rd = 0; reg_wr = 0; rx_data_taken = 0; tx_data_loaded = 0;
    check16("reg_rdata", reg_rdata, m_rd);
    check16("irq", {15'd0, irq}, {15'd0, |(m_stat & m_mask)});
  endtask

  task automatic rd(input logic [7:0] a);  step('0, 1, 0, a, '0, 0, 0); endtask
  task automatic wr(input logic [7:0] a, input logic [15:0] d); step('0, 0, 1, a, d, 0, 0); endtask
  task automatic ev(input logic [6:0] e);  step(e, 0, 0, '0, '0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    tag = "R1"; ev('0); rd(A_MASK); rd(A_STAT); rd(A_VEC);

    // R3 mask write and readback, upper bits dropped
    tag = "R3"; wr(A_MASK, 16'hFFD5); rd(A_MASK); wr(A_MASK, 16'h0000); rd(A_MASK);

    // R2 each event latches with mask off; R4 irq stays low
    tag = "R2";
    for (int i = 0; i < 7; i++) begin ev(7'(1 << i)); rd(A_STAT); end
    tag = "R4"; rd(A_VEC); wr(A_MASK, 16'h0020); ev('0);
    wr(A_STAT, 16'h007F); rd(A_STAT);

    // R5/R6/R7 walk the vector with every source enabled
    tag = "R5"; wr(A_MASK, 16'h007F); ev(7'h7F);
    tag = "R6"; rd(A_VEC); rd(A_VEC); rd(A_VEC); rd(A_VEC); rd(A_VEC); rd(A_STAT);
    tag = "R7"; step('0, 0, 0, '0, '0, 1, 0); rd(A_VEC); rd(A_VEC);
    step('0, 0, 0, '0, '0, 0, 1); rd(A_VEC); rd(A_VEC); rd(A_VEC); rd(A_STAT);

    // R5 sparse enables pick the lowest enabled
    tag = "R5"; wr(A_MASK, 16'h0044); ev(7'h7F); rd(A_VEC); rd(A_VEC); rd(A_VEC);
    wr(A_MASK, 16'h0000); ev('0); rd(A_VEC);

    // R8 write-one-to-clear
    tag = "R8"; wr(A_STAT, 16'h0024); rd(A_STAT); wr(A_STAT, 16'h0000); rd(A_STAT);
    wr(A_STAT, 16'hFFFF); rd(A_STAT);

    // R9 level bits
    tag = "R9"; bus_busy = 1; rd(A_STAT); rx_shift_full = 1; bus_busy = 0; rd(A_STAT);
    rx_shift_full = 0; rd(A_STAT);

    // R10 set wins over clear
    tag = "R10"; wr(A_MASK, 16'h007F);
    step(7'h20, 0, 1, A_STAT, 16'h0020, 0, 0); rd(A_STAT);
    step(7'h08, 0, 0, '0, '0, 1, 0); rd(A_STAT);
    step(7'h01, 1, 0, A_VEC, '0, 0, 0); rd(A_STAT); rd(A_VEC); rd(A_VEC); rd(A_VEC);

    // R11 unmapped reads and vector writes
    tag = "R11"; ev(7'h02); wr(A_VEC, 16'hFFFF); rd(A_MASK); rd(A_STAT);
    rd(8'h10); rd(8'h2C); rd(8'h00);

    // mixed stimulus, compared against the model every cycle
    tag = "R5";
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 5);
      logic [7:0] a = (sel < 2) ? A_VEC : (sel < 4) ? A_STAT : A_MASK;
      logic [6:0] e = ($urandom_range(0, 3) == 0) ? 7'($urandom) : '0;
      bit r = $urandom_range(0, 1);
      bit w = !r && ($urandom_range(0, 3) == 0);
      step(e, r, w, a, 16'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule